// File: doc/BRIEF.md
# Machine Check Response Sequencer

This block decides how the processor reacts when a hardware error detector reports a machine check. It watches a one-cycle event pulse, the machine-check mask bit of the current status word and a maintenance stop switch. From these it takes one of three paths. It can drop the event. It can write a diagnostic log-out record and then stop the machine for good. Or it can write the log-out record and then run a machine interrupt. The interrupt stores the current 64-bit status word to memory and loads a replacement from memory.

All memory traffic is byte-wide and uses one request/acknowledge port. The log-out record is `LOG_LEN` bytes long (a parameter, 4 to 256). It is written upward from address 128. The block does not generate the record's contents: it drives a byte index, and the log source returns the matching byte on `log_data`. Error detection itself is outside the block, and so is what the log bytes mean.

Top module: `mchk_seq`

## Requirements
- R1: If `mc_mask` is 0 in the cycle a sequence would start, the event is dropped. There is no memory request, `busy` stays low, `halted` stays low and `done` stays low.
- R2: If the event is not dropped, the block first writes `LOG_LEN` bytes, one at a time, to addresses 128 up to 128+`LOG_LEN`-1 in ascending order. While the byte for index i is being written, `log_index` equals i and the byte written is `log_data`.
- R3: With the stop switch sampled off, the log-out is followed by a store of the saved status word to addresses 48..55. Bits 63:56 go to address 48 and the remaining bytes follow in descending significance.
- R4: After the store, eight bytes are read from addresses 112..119. The byte at 112 becomes bits 63:56 of `new_status`, and the other bytes fill the lower bits in order.
- R5: `done` and `new_valid` are high together for exactly one cycle. That cycle is the one right after the acknowledge of the last read. `new_status` holds the loaded word from then on.
- R6: With the stop switch sampled on, the cycle after the last log-out acknowledge enters the halt state. `halted` is then high and stays high until reset. In this state there are no memory requests and no `done` pulse, and new events are ignored.
- R7: An event that arrives while a sequence is running (from the first log-out byte through the `done` cycle) is held pending. It starts a new sequence once the current one returns to idle. Any number of events during one sequence give exactly one further sequence.
- R8: After reset, `busy`, `halted`, `done`, `new_valid` and `mem_req` are all 0.
- R9: `mc_mask`, `stop_sw` and `cur_status` are sampled only in the cycle a sequence starts. Later changes have no effect on that sequence.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_addr` and `mem_we` stay unchanged. A byte moves in each cycle where both are high. Writes are `mem_we`=1 and reads are `mem_we`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_event | input | 1 | Machine-check event pulse |
| mc_mask | input | 1 | Machine-check mask bit of the current status word |
| stop_sw | input | 1 | Maintenance stop switch; 1 turns the response into a halt |
| cur_status | input | 64 | Current status word |
| log_index | output | CNT_W | Index of the log-out byte being written |
| log_data | input | 8 | Log-out byte for `log_index` |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` on reads |
| mem_ack | input | 1 | Transfer completes when high with `mem_req` |
| busy | output | 1 | A log-out or interrupt sequence is in progress |
| halted | output | 1 | Sticky error-stop state |
| done | output | 1 | One-cycle pulse at the end of the interrupt swap |
| new_status | output | 64 | Status word loaded by the last interrupt |
| new_valid | output | 1 | Strobe marking `new_status` as freshly loaded |

## Verification
The hardest case to reach is a pending event that starts a second sequence under different sampled conditions. It must arrive after the first sequence has started and before it returns to idle, and the switch must change during that same window. The stimulus uses a memory responder that delays each acknowledge by two cycles, which stretches the first sequence. It fires several events and flips the stop switch part-way through. The expected result is one completed interrupt followed by exactly one further log-out that ends in a halt. A behavioural model in the bench predicts the port outputs on every cycle.

// File: rtl/mchk_pkg.sv
// Shared constants and state type for the machine-check response sequencer.
// Assumes an 8-byte status word moved most significant byte first.
package mchk_pkg;
    localparam int WORD_BYTES = 8;
    localparam int WORD_BITS  = WORD_BYTES * 8;
    localparam int SEL_W      = $clog2(WORD_BYTES);
    localparam int SAVE_BASE  = 48;
    localparam int LOAD_BASE  = 112;
    localparam int DUMP_BASE  = 128;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_DUMP = 3'd1,
        S_SAVE = 3'd2,
        S_LOAD = 3'd3,
        S_FIN  = 3'd4,
        S_HALT = 3'd5
    } seq_state_t;
endpackage

// File: rtl/mchk_pend.sv
// Pending-event holder and launch decision.
// An event seen while a sequence is active is remembered. In idle, a fresh
// event or a remembered one produces a launch request. Outside the active
// states the memory is cleared. Assumes idle and active are never both high.
module mchk_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic active,
    input  logic idle,
    output logic launch
);
    logic pend_q;

    // Remember events during an active sequence; forget them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (active) begin
            pend_q <= pend_q | evt;
        end else begin
            pend_q <= 1'b0;
        end
    end

    // Launch from idle on a new or a held event.
    always_comb begin
        launch = idle & (evt | pend_q);
    end
endmodule

// File: rtl/mchk_byte_ctr.sv
// Byte counter for one transfer phase.
// Counts acknowledged bytes and wraps to zero after the last byte of the
// phase. The phase length is LOG_LEN in the dump phase and WORD_BYTES
// otherwise. A clear input forces zero.
module mchk_byte_ctr
    import mchk_pkg::*;
#(
    parameter int LOG_LEN = 16,
    parameter int CNT_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic             in_dump,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    localparam logic [CNT_W-1:0] DUMP_LAST = CNT_W'(LOG_LEN - 1);
    localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    // Choose the final index of the current phase.
    always_comb begin
        limit = in_dump ? DUMP_LAST : WORD_LAST;
        last  = (cnt_q == limit);
    end

    // Advance on each transferred byte; wrap at the end of a phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/mchk_word_io.sv
// Status word serializer and deserializer.
// Captures the outgoing status word at launch and presents byte 'sel'
// (byte 0 = most significant). Shifts incoming bytes into the new word, with
// the first byte ending in the top position. Assumes sel < WORD_BYTES while
// saving.
module mchk_word_io
    import mchk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 capture,
    input  logic [WORD_BITS-1:0] cur_word,
    input  logic [SEL_W-1:0]     sel,
    input  logic                 shift_en,
    input  logic [7:0]           rdata,
    output logic [7:0]           save_byte,
    output logic [WORD_BITS-1:0] new_word
);
    logic [WORD_BITS-1:0] old_q;
    logic [WORD_BITS-1:0] new_q;
    logic [7:0]           byte_arr [WORD_BYTES];

    // Hold the word to be saved for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            old_q <= '0;
        end else if (capture) begin
            old_q <= cur_word;
        end
    end

    // Slice the held word into bytes, most significant first.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_slice
        assign byte_arr[g] = old_q[WORD_BITS-1-8*g -: 8];
    end

    // Select the byte being written.
    always_comb begin
        save_byte = byte_arr[sel];
    end

    // Shift each read byte in from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_q <= '0;
        end else if (shift_en) begin
            new_q <= {new_q[WORD_BITS-9:0], rdata};
        end
    end

    assign new_word = new_q;
endmodule

// File: rtl/mchk_seq.sv
// Machine-check response sequencer (top).
// On a machine-check event whose mask is set, it writes a LOG_LEN-byte
// record from address 128. It then halts for good (stop switch on) or swaps
// status words (store to 48, load from 112). Mask, switch and current word
// are sampled at launch. Assumes the log source holds log_data for
// log_index and that memory holds each request until it acknowledges.
module mchk_seq
    import mchk_pkg::*;
#(
    parameter int  LOG_LEN = 16,
    parameter int  ADDR_W  = 16,
    localparam int CNT_W   = (LOG_LEN > WORD_BYTES) ? $clog2(LOG_LEN) : $clog2(WORD_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mc_event,
    input  logic                 mc_mask,
    input  logic                 stop_sw,
    input  logic [WORD_BITS-1:0] cur_status,
    output logic [CNT_W-1:0]     log_index,
    input  logic [7:0]           log_data,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [7:0]           mem_wdata,
    input  logic [7:0]           mem_rdata,
    input  logic                 mem_ack,
    output logic                 busy,
    output logic                 halted,
    output logic                 done,
    output logic [WORD_BITS-1:0] new_status,
    output logic                 new_valid
);
    seq_state_t       state_q, state_d;
    logic             stop_q;
    logic             launch;
    logic             start;
    logic             xfer;
    logic             active;
    logic             is_idle;
    logic             in_dump;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic [7:0]       save_byte;
    logic             phase_end;

    // Decode the state classes used by the helpers.
    always_comb begin
        is_idle   = (state_q == S_IDLE);
        in_dump   = (state_q == S_DUMP);
        active    = (state_q == S_DUMP) || (state_q == S_SAVE) ||
                    (state_q == S_LOAD) || (state_q == S_FIN);
        mem_req   = (state_q == S_DUMP) || (state_q == S_SAVE) || (state_q == S_LOAD);
        mem_we    = (state_q == S_DUMP) || (state_q == S_SAVE);
        xfer      = mem_req & mem_ack;
        phase_end = xfer & last;
        start     = launch & mc_mask;
    end

    mchk_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt    (mc_event),
        .active (active),
        .idle   (is_idle),
        .launch (launch)
    );

    mchk_byte_ctr #(
        .LOG_LEN (LOG_LEN),
        .CNT_W   (CNT_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (is_idle),
        .step    (xfer),
        .in_dump (in_dump),
        .cnt     (cnt),
        .last    (last)
    );

    mchk_word_io u_word (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (start),
        .cur_word  (cur_status),
        .sel       (cnt[SEL_W-1:0]),
        .shift_en  (xfer && (state_q == S_LOAD)),
        .rdata     (mem_rdata),
        .save_byte (save_byte),
        .new_word  (new_status)
    );

    // Next-state selection for the response sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start)     state_d = S_DUMP;
            S_DUMP: if (phase_end) state_d = stop_q ? S_HALT : S_SAVE;
            S_SAVE: if (phase_end) state_d = S_LOAD;
            S_LOAD: if (phase_end) state_d = S_FIN;
            S_FIN:                 state_d = S_IDLE;
            S_HALT:                state_d = S_HALT;
            default:               state_d = S_IDLE;
        endcase
    end

    // State register; halt is left only through reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Latch the stop switch at the start of a sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q <= 1'b0;
        end else if (start) begin
            stop_q <= stop_sw;
        end
    end

    // Address and write data for the current phase.
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            S_DUMP: begin
                mem_addr  = ADDR_W'(DUMP_BASE) + ADDR_W'(cnt);
                mem_wdata = log_data;
            end
            S_SAVE: begin
                mem_addr  = ADDR_W'(SAVE_BASE) + ADDR_W'(cnt);
                mem_wdata = save_byte;
            end
            S_LOAD: begin
                mem_addr  = ADDR_W'(LOAD_BASE) + ADDR_W'(cnt);
            end
            default: begin
                mem_addr  = '0;
                mem_wdata = '0;
            end
        endcase
    end

    // Status outputs.
    always_comb begin
        log_index = cnt;
        busy      = active;
        halted    = (state_q == S_HALT);
        done      = (state_q == S_FIN);
        new_valid = (state_q == S_FIN);
    end
endmodule

// File: rtl/mchk_seq_chk.sv
// Property checker for mchk_seq, attached by bind below.
// Observes only the top-level ports.
module mchk_seq_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mc_mask,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              busy,
    input logic              halted,
    input logic              done
);
    AST_MASKED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !halted && !mc_mask) |=> !busy);  // R1

    AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R5

    AST_DONE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_ack && !mem_we));  // R5

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);  // R6

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_req && !done && !busy));  // R6

    AST_HALT_AFTER_LOG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(mem_req && mem_ack && mem_we && (int'(mem_addr) >= 128)));  // R2
endmodule

bind mchk_seq mchk_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mc_mask  (mc_mask),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .busy     (busy),
    .halted   (halted),
    .done     (done)
);

// File: tb/mchk_seq_test.sv
// Bench for mchk_seq: behavioural cycle model compared on every clock,
// a byte memory responder with programmable acknowledge delay, and
// scenario checks on memory contents.
module mchk_seq_test;
    localparam int LOG_LEN = 16;
    localparam int ADDR_W  = 16;
    localparam int CNT_W   = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              mc_event, mc_mask, stop_sw;
    logic [63:0]       cur_status;
    logic [CNT_W-1:0]  log_index;
    logic [7:0]        log_data;
    logic              mem_req, mem_we, mem_ack;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;
    logic              busy, halted, done, new_valid;
    logic [63:0]       new_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mchk_seq #(.LOG_LEN(LOG_LEN), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .mc_event(mc_event), .mc_mask(mc_mask),
        .stop_sw(stop_sw), .cur_status(cur_status), .log_index(log_index),
        .log_data(log_data), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .busy(busy), .halted(halted), .done(done),
        .new_status(new_status), .new_valid(new_valid)
    );

    function automatic logic [7:0] log_pat(int i);
        return 8'((i * 37 + 11) % 256);
    endfunction

    assign log_data = log_pat(int'(log_index));

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Byte memory with acknowledge delay
    logic [7:0] mem [0:511];
    int ack_lat = 0;
    int wcnt = 0;
    int dump_wr = 0;

    always @(negedge clk) begin
        if (mem_req) begin
            if (wcnt >= ack_lat) begin
                mem_ack = 1'b1;
                wcnt = 0;
                if (mem_we) begin
                    mem[mem_addr[8:0]] = mem_wdata;
                    if (mem_addr >= 16'd128) dump_wr++;
                end else begin
                    mem_rdata = mem[mem_addr[8:0]];
                end
            end else begin
                mem_ack = 1'b0;
                wcnt++;
            end
        end else begin
            mem_ack = 1'b0;
            wcnt = 0;
        end
    end

    // Behavioural reference model: 0 idle,1 log,2 store,3 load,4 finish,5 halt
    int ph = 0, idx = 0, pend = 0;
    logic sw_s = 1'b0;
    logic [63:0] st_s = '0, nw_m = '0;

    always @(posedge clk) begin : mdl
        int old;
        old = ph;
        if (!rst_n) begin
            ph = 0; idx = 0; pend = 0; nw_m = '0;
        end else begin
            case (ph)
                0: if (mc_event || pend != 0) begin
                       pend = 0;
                       if (mc_mask) begin
                           ph = 1; idx = 0; sw_s = stop_sw; st_s = cur_status;
                       end
                   end
                1: if (mem_ack) begin
                       if (idx == LOG_LEN - 1) begin idx = 0; ph = sw_s ? 5 : 2; end
                       else idx++;
                   end
                2: if (mem_ack) begin
                       if (idx == 7) begin idx = 0; ph = 3; end else idx++;
                   end
                3: if (mem_ack) begin
                       nw_m = {nw_m[55:0], mem_rdata};
                       if (idx == 7) begin idx = 0; ph = 4; end else idx++;
                   end
                4: ph = 0;
                default: ;
            endcase
            if (old >= 1 && old <= 4 && mc_event) pend = 1;
            if (ph == 5) pend = 0;
        end
    end

    // Per-cycle comparison, sampled after outputs settle
    int done_cnt = 0, req_cnt = 0, halt_req = 0;
    logic [63:0] new_cap = '0;

    always @(posedge clk) begin
        logic e_req, e_we;
        int e_addr;
        logic [7:0] e_wd;
        #2;
        e_req = (ph >= 1 && ph <= 3);
        e_we  = (ph == 1 || ph == 2);
        e_addr = (ph == 1) ? 128 + idx : (ph == 2) ? 48 + idx : (ph == 3) ? 112 + idx : 0;
        e_wd  = (ph == 1) ? log_pat(idx) : (ph == 2) ? st_s[63 - 8*idx -: 8] : 8'h00;
        check(busy === (ph >= 1 && ph <= 4), "R1", "busy", busy, (ph >= 1 && ph <= 4));
        check(halted === (ph == 5), "R6", "halted", halted, (ph == 5));
        check(done === (ph == 4) && new_valid === (ph == 4), "R5", "done/new_valid",
              {done, new_valid}, {2{ph == 4}});
        check(mem_req === e_req, "R10", "mem_req", mem_req, e_req);
        if (e_req) begin
            check(mem_we === e_we && int'(mem_addr) == e_addr, "R10", "we/addr",
                  {mem_we, mem_addr}, {e_we, 16'(e_addr)});
            if (e_we) check(mem_wdata === e_wd, "R2", "wdata", mem_wdata, e_wd);
            if (ph == 1) check(int'(log_index) == idx, "R2", "log_index", log_index, idx);
        end
        if (ph == 4) check(new_status === nw_m, "R4", "new_status", new_status, nw_m);
        if (done) begin done_cnt++; new_cap = new_status; end
        if (mem_req) req_cnt++;
        if (halted && mem_req) halt_req++;
    end

    task automatic pulse();
        @(negedge clk) mc_event = 1'b1;
        @(negedge clk) mc_event = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [63:0] sa, sb, exp_new;
        int bad;
        mem_ack = 1'b0; mem_rdata = 8'h00;
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) mem[112 + i] = 8'(8'hA0 + i * 3);
        rst_n = 1'b0; mc_event = 1'b0; mc_mask = 1'b0; stop_sw = 1'b0; cur_status = '0;
        repeat (3) @(negedge clk);
        check({busy, halted, done, new_valid, mem_req} == 5'b0, "R8", "reset outputs",
              {busy, halted, done, new_valid, mem_req}, 0);
        rst_n = 1'b1;

        // R1: masked event is dropped
        mc_mask = 1'b0;
        pulse();
        repeat (20) @(negedge clk);
        check(done_cnt == 0 && req_cnt == 0, "R1", "masked event activity", req_cnt + done_cnt, 0);

        // R2 R3 R4 R5 R9: interrupt with immediate acknowledges
        sa = 64'h0123_4567_89AB_CDEF;
        mc_mask = 1'b1; stop_sw = 1'b0; cur_status = sa;
        @(negedge clk) mc_event = 1'b1;
        @(negedge clk) begin mc_event = 1'b0; mc_mask = 1'b0; cur_status = ~sa; stop_sw = 1'b1; end
        while (done_cnt < 1) @(negedge clk);
        stop_sw = 1'b0;
        repeat (2) @(negedge clk);
        bad = 0;
        for (int i = 0; i < LOG_LEN; i++) if (mem[128 + i] !== log_pat(i)) bad++;
        check(bad == 0 && dump_wr == LOG_LEN, "R2", "log-out bytes/count", dump_wr, LOG_LEN);
        check({mem[48], mem[49], mem[50], mem[51], mem[52], mem[53], mem[54], mem[55]} === sa,
              "R3", "stored status",
              {mem[48], mem[49], mem[50], mem[51], mem[52], mem[53], mem[54], mem[55]}, sa);
        check(mem[48] === 8'h01, "R9", "status sampled at start", mem[48], 8'h01);
        exp_new = '0;
        for (int i = 0; i < 8; i++) exp_new = {exp_new[55:0], 8'(8'hA0 + i * 3)};
        check(new_cap === exp_new, "R4", "loaded status", new_cap, exp_new);
        check(done_cnt == 1 && halted == 1'b0, "R5", "single done pulse", done_cnt, 1);

        // R7 R6 R9: pending events during a slow sequence, switch turned on mid-way
        sb = 64'hFEDC_BA98_7654_3210;
        ack_lat = 2; mc_mask = 1'b1; cur_status = sb;
        pulse();
        repeat (10) @(negedge clk);
        pulse(); pulse(); pulse();
        stop_sw = 1'b1;
        while (!halted) @(negedge clk);
        check(done_cnt == 2, "R7", "interrupts before halt", done_cnt, 2);
        check(dump_wr == 3 * LOG_LEN, "R7", "log-out bytes total", dump_wr, 3 * LOG_LEN);
        check({mem[48], mem[49], mem[50], mem[51], mem[52], mem[53], mem[54], mem[55]} === sb,
              "R3", "second stored status",
              {mem[48], mem[49], mem[50], mem[51], mem[52], mem[53], mem[54], mem[55]}, sb);
        halt_req = 0;
        pulse();
        repeat (30) @(negedge clk);
        check(halted && !busy && halt_req == 0 && done_cnt == 2, "R6", "halt sticky and quiet",
              {halted, busy, 8'(halt_req)}, 10'h200);

        // R8: reset leaves halt
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(halted == 1'b0 && busy == 1'b0, "R8", "halt cleared by reset", halted, 0);
        rst_n = 1'b1;

        // R10: long acknowledge delay, full interrupt
        stop_sw = 1'b0; ack_lat = 3; mc_mask = 1'b1;
        pulse();
        while (done_cnt < 3) @(negedge clk);
        repeat (2) @(negedge clk);
        check(!busy && !halted, "R10", "slow handshake completes", {busy, halted}, 0);
        finish_run();
    end
endmodule